// File: doc/BRIEF.md
# Page Key Access Checker

This block rules on whether a memory access may touch a physical page. Each page carries a protection key in an on-chip key table indexed by physical page number. The running application holds a small set of keys in a key register. When an access request arrives, the block reads the page's key and compares it against every held key at once. It grants the access when a live slot holds that key and faults it otherwise. Two applications share a page simply by both holding its key.

The key register is loaded through a CSR-style write port. One select value writes the packed key word and the other writes the slot-valid mask. A separate load port updates the key of a single page in the table. Every request receives exactly one response, one cycle later, carrying the request's tag. The surrounding pipeline can therefore match results to accesses without a handshake.

Top module: `keyAccessCheck`

## Requirements
- R1: After reset no response is presented and the slot-valid mask is all zero, so every request answered before a mask write faults.
- R2: A request sampled on a clock edge is answered on the following edge with rspValid high and rspTag equal to the request's tag; with no request there is no response.
- R3: A request is granted when at least one valid slot holds a key equal to the page's stored key, whichever slot it is.
- R4: A request is faulted when no valid slot holds the page's key.
- R5: A slot whose valid bit is clear never produces a grant, even when its key equals the page's key.
- R6: A CSR write with csrSel = 0 loads the six 10-bit keys from csrWdata, slot i taken from bits 10*i+9 down to 10*i; bits 63:60 are ignored.
- R7: A CSR write with csrSel = 1 loads the slot-valid mask from csrWdata bits 5:0, bit i enabling slot i.
- R8: A table write stores a new key for page tblPage; a request for the same page on the same edge sees the old key, and later requests see the new one.
- R9: A CSR write on the same edge as a request already applies to that request's decision.
- R10: rspGrant and rspFault are never both high, exactly one is high while rspValid is high, and both are low otherwise.
- R11: Requests on consecutive cycles are each answered in order with their own tag and decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWe | input | 1 | Key register write strobe |
| csrSel | input | 1 | 0 selects the packed key word, 1 selects the valid mask |
| csrWdata | input | 64 | Key register write data |
| tblWe | input | 1 | Key table write strobe |
| tblPage | input | 8 | Page whose key is written |
| tblKey | input | 10 | New key for tblPage |
| reqValid | input | 1 | Access request strobe |
| reqPage | input | 8 | Physical page of the access |
| reqTag | input | 4 | Tag returned with the decision |
| rspValid | output | 1 | Decision present |
| rspGrant | output | 1 | Access permitted |
| rspFault | output | 1 | Access refused |
| rspTag | output | 4 | Tag of the decided request |

## Verification
The decision path is exercised with a full mask and the match placed in each of the six slot positions in turn. This separates a working parallel compare from one that ignores or misplaces a slot. Pages whose keys no slot holds show that a mismatch faults rather than defaulting to grant. Masks with a single slot or a single hole tell valid-bit gating apart from the key compare itself. Same-edge collisions of a request with a table write and with a CSR write pin down which value each ordering must see. Back-to-back requests with changing tags expose any slip in the one-cycle alignment.

// File: rtl/keyPkg.sv
package keyPkg;
  localparam int KEY_W_DEF   = 10;
  localparam int SLOTS_DEF   = 6;
  localparam int PAGE_W_DEF  = 8;
  localparam int TAG_W_DEF   = 4;
  localparam int CSR_W_DEF   = 64;

  localparam logic SEL_KEYS = 1'b0;
  localparam logic SEL_MASK = 1'b1;

  typedef struct packed {
    logic reqAccept;
    logic tblWrite;
    logic keyWrite;
    logic maskWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/keyCtrl.sv
module keyCtrl
  import keyPkg::*;
#(
  parameter int TAG_W = TAG_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             csrWe,
  input  logic             csrSel,
  input  logic             tblWe,
  output ctrlStrobes_t     strobes,
  output logic             rspValid,
  output logic [TAG_W-1:0] rspTag
);

  always_comb begin
    strobes.reqAccept = reqValid;
    strobes.tblWrite  = tblWe;
    strobes.keyWrite  = csrWe && (csrSel == SEL_KEYS);
    strobes.maskWrite = csrWe && (csrSel == SEL_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTag   <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rspTag <= reqTag;
    end
  end

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  no_idle_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R11
  rsp_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspTag == $past(reqTag)));

endmodule

// File: rtl/keyMatch.sv
module keyMatch #(
  parameter int KEY_W = 10,
  parameter int SLOTS = 6
) (
  input  logic [SLOTS*KEY_W-1:0] slotKeys,
  input  logic [SLOTS-1:0]       slotValid,
  input  logic [KEY_W-1:0]       pageKey,
  output logic [SLOTS-1:0]       hitVec,
  output logic                   anyHit
);

  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    assign hitVec[i] = slotValid[i] && (slotKeys[i*KEY_W +: KEY_W] == pageKey);
  end

  assign anyHit = |hitVec;

endmodule

// File: rtl/keyDatapath.sv
module keyDatapath
  import keyPkg::*;
#(
  parameter int KEY_W  = KEY_W_DEF,
  parameter int SLOTS  = SLOTS_DEF,
  parameter int PAGE_W = PAGE_W_DEF,
  parameter int CSR_W  = CSR_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CSR_W-1:0]  csrWdata,
  input  logic [PAGE_W-1:0] tblPage,
  input  logic [KEY_W-1:0]  tblKey,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              anyHit
);

  localparam int PAGES    = 1 << PAGE_W;
  localparam int KEY_BITS = SLOTS * KEY_W;

  logic [KEY_W-1:0]    keyTable [PAGES];
  logic [KEY_W-1:0]    pageKey;
  logic [KEY_BITS-1:0] slotKeys;
  logic [SLOTS-1:0]    slotValid;
  logic [SLOTS-1:0]    hitVec;
  logic                unusedHigh;

  assign unusedHigh = ^csrWdata[CSR_W-1:KEY_BITS];

  // table: read returns the pre-write content on a same-page collision
  always_ff @(posedge clk) begin
    if (strobes.tblWrite) keyTable[tblPage] <= tblKey;
    if (strobes.reqAccept) pageKey <= keyTable[reqPage];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotKeys  <= '0;
      slotValid <= '0;
    end else begin
      if (strobes.keyWrite)  slotKeys  <= csrWdata[KEY_BITS-1:0];
      if (strobes.maskWrite) slotValid <= csrWdata[SLOTS-1:0];
    end
  end

  keyMatch #(.KEY_W(KEY_W), .SLOTS(SLOTS)) uMatch (
    .slotKeys (slotKeys),
    .slotValid(slotValid),
    .pageKey  (pageKey),
    .hitVec   (hitVec),
    .anyHit   (anyHit)
  );

  // R6
  key_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.keyWrite |=> (slotKeys == $past(csrWdata[KEY_BITS-1:0])));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWrite |=> (slotValid == $past(csrWdata[SLOTS-1:0])));

  // R8
  table_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tblWrite |=> (keyTable[$past(tblPage)] == $past(tblKey)));

endmodule

// File: rtl/keyAccessCheck.sv
module keyAccessCheck
  import keyPkg::*;
#(
  parameter int KEY_W  = KEY_W_DEF,
  parameter int SLOTS  = SLOTS_DEF,
  parameter int PAGE_W = PAGE_W_DEF,
  parameter int TAG_W  = TAG_W_DEF,
  parameter int CSR_W  = CSR_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWe,
  input  logic              csrSel,
  input  logic [CSR_W-1:0]  csrWdata,
  input  logic              tblWe,
  input  logic [PAGE_W-1:0] tblPage,
  input  logic [KEY_W-1:0]  tblKey,
  input  logic              reqValid,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspFault,
  output logic [TAG_W-1:0]  rspTag
);

  ctrlStrobes_t strobes;
  logic         anyHit;

  keyCtrl #(.TAG_W(TAG_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqTag  (reqTag),
    .csrWe   (csrWe),
    .csrSel  (csrSel),
    .tblWe   (tblWe),
    .strobes (strobes),
    .rspValid(rspValid),
    .rspTag  (rspTag)
  );

  keyDatapath #(.KEY_W(KEY_W), .SLOTS(SLOTS), .PAGE_W(PAGE_W), .CSR_W(CSR_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .csrWdata(csrWdata),
    .tblPage (tblPage),
    .tblKey  (tblKey),
    .reqPage (reqPage),
    .anyHit  (anyHit)
  );

  assign rspGrant = rspValid && anyHit;
  assign rspFault = rspValid && !anyHit;

endmodule

// File: tb/keyAccessCheck_test.sv
module keyAccessCheck_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWe = 1'b0;
  logic        csrSel = 1'b0;
  logic [63:0] csrWdata = '0;
  logic        tblWe = 1'b0;
  logic [7:0]  tblPage = '0;
  logic [9:0]  tblKey = '0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqPage = '0;
  logic [3:0]  reqTag = '0;
  logic        rspValid, rspGrant, rspFault;
  logic [3:0]  rspTag;

  always #2 clk = ~clk;

  keyAccessCheck uut (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata),
    .tblWe(tblWe), .tblPage(tblPage), .tblKey(tblKey),
    .reqValid(reqValid), .reqPage(reqPage), .reqTag(reqTag),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspFault(rspFault), .rspTag(rspTag)
  );

  typedef struct {
    int         due;
    logic       grant;
    logic [3:0] tag;
    string      req;
  } expItem_t;

  expItem_t   expQ[$];
  int         nRun = 0;
  int         nFail = 0;
  int         cyc = 0;
  logic [9:0] mKeys [6];
  logic [5:0] mMask = '0;
  logic [9:0] mTbl [256];
  logic [3:0] tagCnt = '0;
  bit         finished = 0;

  always @(posedge clk) cyc++;

  function automatic logic [9:0] kf(input int p);
    return 10'((p * 37 + 5) % 1024);
  endfunction

  function automatic logic [63:0] pack6(input logic [9:0] a, b, c, d, e, f);
    return {4'hF, f, e, d, c, b, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(input logic rv, input logic [7:0] pg, input logic cwe,
                      input logic csel, input logic [63:0] cdat, input logic twe,
                      input logic [7:0] tp, input logic [9:0] tk, input string req);
    expItem_t e;
    logic g;
    @(negedge clk);
    reqValid = rv; reqPage = pg; reqTag = tagCnt;
    csrWe = cwe; csrSel = csel; csrWdata = cdat;
    tblWe = twe; tblPage = tp; tblKey = tk;
    if (cwe) begin
      if (csel) mMask = cdat[5:0];
      else for (int i = 0; i < 6; i++) mKeys[i] = cdat[i*10 +: 10];
    end
    if (rv) begin
      g = 1'b0;
      for (int i = 0; i < 6; i++) if (mMask[i] && mKeys[i] == mTbl[pg]) g = 1'b1;
      e.due = cyc + 1; e.grant = g; e.tag = tagCnt; e.req = req;
      expQ.push_back(e);
      tagCnt++;
    end
    if (twe) mTbl[tp] = tk;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic ask(input logic [7:0] pg, input string req);
    step(1, pg, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic setMask(input logic [5:0] m);
    step(0, 0, 1, 1, {58'h0, m}, 0, 0, 0, "");
  endtask
  task automatic setKeys(input logic [63:0] w);
    step(0, 0, 1, 0, w, 0, 0, 0, "");
  endtask

  // scoreboard monitor
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (expQ.size() > 0 && expQ[0].due == cyc) begin
          e = expQ.pop_front();
          check(rspValid === 1'b1, "R2", "rspValid", int'(rspValid), 1);
          check(rspTag === e.tag, "R11", "rspTag", int'(rspTag), int'(e.tag));
          check(rspGrant === e.grant, e.req, "rspGrant", int'(rspGrant), int'(e.grant));
          check((rspGrant ^ rspFault) === 1'b1, "R10", "grant^fault",
                int'(rspGrant ^ rspFault), 1);
        end else begin
          check(rspValid === 1'b0, "R2", "spurious rspValid", int'(rspValid), 0);
          check((rspGrant | rspFault) === 1'b0, "R10", "grant|fault idle",
                int'(rspGrant | rspFault), 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    #800000;
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mKeys[i] = '0;
    for (int i = 0; i < 256; i++) mTbl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rspValid === 1'b0, "R1", "rspValid in reset", int'(rspValid), 0);
    check((rspGrant | rspFault) === 1'b0, "R1", "grant|fault in reset",
          int'(rspGrant | rspFault), 0);
    rstN = 1'b1;
    // load table pages 0..15
    for (int p = 0; p < 16; p++) step(0, 0, 0, 0, 0, 1, 8'(p), kf(p), "");
    // R1: keys written but mask still clear after reset
    setKeys(pack6(kf(1), kf(2), kf(3), kf(4), kf(5), kf(6)));
    ask(3, "R1");
    setMask(6'h3F);
    // R3, R6: each slot position grants
    for (int p = 1; p <= 6; p++) begin ask(8'(p), "R3"); idle(); end
    // R4: unheld keys fault
    ask(0, "R4"); ask(7, "R4"); ask(9, "R4"); idle();
    // R5: hole at slot 2
    setMask(6'b111011);
    ask(3, "R5"); ask(2, "R3"); idle();
    // R7: only slot 5 live
    setMask(6'b100000);
    ask(6, "R7"); ask(1, "R7"); idle();
    setMask(6'h3F);
    // R11: back-to-back
    for (int p = 1; p <= 8; p++) ask(8'(p), "R11");
    idle();
    // R8: same-edge table write sees old key, later sees new
    step(1, 1, 0, 0, 0, 1, 1, 10'd999, "R8");
    ask(1, "R8"); idle();
    step(0, 0, 0, 0, 0, 1, 1, kf(1), "");
    ask(1, "R8"); idle();
    // R9: same-edge CSR writes apply to the request
    step(1, 2, 1, 1, 64'h0, 0, 0, 0, "R9");
    step(1, 2, 1, 1, 64'h3F, 0, 0, 0, "R9");
    step(1, 9, 1, 0, pack6(kf(9), kf(2), kf(3), kf(4), kf(5), kf(6)), 0, 0, 0, "R9");
    ask(1, "R6");
    repeat (4) idle();
    finished = 1;
    check(expQ.size() == 0, "R2", "pending responses", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule